// File: doc/BRIEF.md
# Conflict-Driven Selective Instruction Cache

This block is a small instruction cache for a processor whose program memory and data memory sit on separate buses. Program memory sometimes also holds operands, so a cycle can need both an instruction fetch and an operand read from program memory. Only a fetch that collides with such an operand read is worth caching. The block therefore allocates an entry only on such a collision. A plain fetch never fills it.

When a colliding fetch hits, the cached word is returned in the same cycle. Program memory then serves the operand, the data bus serves the second operand, and the instruction comes from the cache. When a colliding fetch misses, the block raises a stall request for that cycle and records the victim slot. It writes the word that program memory returns next into that slot.

The organisation is two-way set-associative. The set index comes from the low fetch-address bits and the tag from the rest. Each set has one least-recently-used bit. A synchronous flush empties the whole cache in one cycle.

Top module: `sel_icache`

## Requirements
- R1: After reset no fetch hits: `hit_o` and `stall_o` are low while no fetch is presented, and the first colliding fetch to any address requests a stall.
- R2: A collision is a cycle with `fetch_valid_i` and `pm_data_i` both high. A colliding fetch that misses raises `stall_o` in that same cycle with `hit_o` low. `stall_o` is never high outside a collision.
- R3: After a colliding miss, the first later cycle with `mem_valid_i` high stores `mem_insn_i` for that address. A later colliding fetch to the address raises `hit_o` in the same cycle, puts the stored word on `hit_insn_o`, and keeps `stall_o` low.
- R4: A fetch without a collision never raises `hit_o` or `stall_o`, even when the address is resident. It allocates nothing and leaves the replacement order unchanged. `hit_insn_o` is zero whenever `hit_o` is low.
- R5: Each set holds two ways. Two addresses with equal index bits (`fetch_addr_i[IDX_W-1:0]`) and different tags are resident together.
- R6: The victim of a fill is chosen in this order: an invalid way (way 0 before way 1), then the least-recently-used way. A colliding hit and a fill each make their way the most recent. When both touch one set in a cycle, the hit is applied last.
- R7: `flush_i` invalidates every entry in one cycle, resets the replacement order, and cancels a pending fill. It wins over a fill or allocation in the same cycle.
- R8: While a fill is pending, a further colliding miss still raises `stall_o` but allocates no entry.
- R9: `mem_valid_i` with no pending fill stores nothing.
- R10: Capacity is the parameter `WORDS` (32-bit words, up to 128), split into `WORDS/2` sets of two ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Synchronous invalidate of all entries |
| fetch_valid_i | input | 1 | Instruction fetch present this cycle |
| fetch_addr_i | input | ADDR_W | Fetch word address |
| pm_data_i | input | 1 | Program memory also carries an operand read this cycle |
| mem_valid_i | input | 1 | Program memory returns an instruction word |
| mem_insn_i | input | INSN_W | Instruction word from program memory |
| hit_o | output | 1 | Colliding fetch served from the cache |
| hit_insn_o | output | INSN_W | Cached instruction, zero without a hit |
| stall_o | output | 1 | Colliding fetch missed; pipeline must wait |

## Verification
A colliding hit or miss lookup can fall in the same cycle as the fill of an earlier miss. The same cycle can also carry a flush. The bench provokes both cases: it returns a memory word in the cycle where another collision is presented, sometimes to the same set, and it raises a flush while a fill is outstanding. A reference model applies the rule order from R6 to R8 and judges the outcome. It checks that the fill lands in the recorded way, that a same-set hit ends up most recent, and that a flushed fill leaves no trace.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // choose the way to replace: free way 0, then free way 1, then the LRU way
  function automatic logic pick_victim(input logic vld0, input logic vld1, input logic lru_way);
    if (!vld0)      return 1'b0;
    else if (!vld1) return 1'b1;
    else            return lru_way;
  endfunction

  // the way a set replaces next once the given way was used
  function automatic logic other_way(input logic used_way);
    return ~used_way;
  endfunction
endpackage

// File: rtl/sic_tags.sv
module sic_tags #(
  parameter int SETS  = 32,
  parameter int IDX_W = 5,
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic [1:0]       way_hit_o,
  output logic [1:0]       way_vld_o
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else if (flush_i) begin
        vld_q <= '0;
      end else if (wr_en_i && (wr_way_i == 1'(w))) begin
        vld_q[wr_idx_i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en_i && (wr_way_i == 1'(w))) tag_q[wr_idx_i] <= wr_tag_i;
    end

    assign way_vld_o[w] = vld_q[rd_idx_i];
    assign way_hit_o[w] = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  end
endmodule

// File: rtl/sic_data.sv
module sic_data #(
  parameter int SETS   = 32,
  parameter int IDX_W  = 5,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              rd_way_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_way_i,
  input  logic [INSN_W-1:0] wr_data_i,
  output logic [INSN_W-1:0] rd_data_o
);
  logic [INSN_W-1:0] rd_each [2];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [INSN_W-1:0] mem_q [SETS];
    always_ff @(posedge clk) begin
      if (wr_en_i && (wr_way_i == 1'(w))) mem_q[wr_idx_i] <= wr_data_i;
    end
    assign rd_each[w] = mem_q[rd_idx_i];
  end

  assign rd_data_o = rd_way_i ? rd_each[1] : rd_each[0];
endmodule

// File: rtl/sic_lru.sv
module sic_lru #(
  parameter int SETS  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic             fill_way_i,
  input  logic             touch_en_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic             touch_way_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_lru_o
);
  import sic_pkg::*;
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (flush_i) begin
      lru_q <= '0;
    end else begin
      if (fill_en_i)  lru_q[fill_idx_i]  <= other_way(fill_way_i);
      // a hit is applied after a fill to the same set
      if (touch_en_i) lru_q[touch_idx_i] <= other_way(touch_way_i);
    end
  end

  assign rd_lru_o = lru_q[rd_idx_i];
endmodule

// File: rtl/sel_icache.sv
module sel_icache #(
  parameter int ADDR_W = 12,
  parameter int INSN_W = 32,
  parameter int WORDS  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              pm_data_i,
  input  logic              mem_valid_i,
  input  logic [INSN_W-1:0] mem_insn_i,
  output logic              hit_o,
  output logic [INSN_W-1:0] hit_insn_o,
  output logic              stall_o
);
  import sic_pkg::*;

  localparam int SETS  = WORDS / 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  idx_w;
  logic [TAG_W-1:0]  tag_w;
  logic [1:0]        way_hit_w;
  logic [1:0]        way_vld_w;
  logic              lookup_hit_w;
  logic              hit_way_w;
  logic              lru_w;
  logic              victim_w;
  logic              conflict_w;
  logic              alloc_w;
  logic              fill_w;
  logic [INSN_W-1:0] rd_insn_w;

  logic              pend_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic              pend_way_q;

  assign idx_w = fetch_addr_i[IDX_W-1:0];
  assign tag_w = fetch_addr_i[ADDR_W-1:IDX_W];

  sic_tags #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_i  (flush_i),
    .rd_idx_i (idx_w),
    .rd_tag_i (tag_w),
    .wr_en_i  (fill_w),
    .wr_idx_i (pend_idx_q),
    .wr_way_i (pend_way_q),
    .wr_tag_i (pend_tag_q),
    .way_hit_o(way_hit_w),
    .way_vld_o(way_vld_w)
  );

  sic_data #(.SETS(SETS), .IDX_W(IDX_W), .INSN_W(INSN_W)) u_data (
    .clk      (clk),
    .rd_idx_i (idx_w),
    .rd_way_i (hit_way_w),
    .wr_en_i  (fill_w),
    .wr_idx_i (pend_idx_q),
    .wr_way_i (pend_way_q),
    .wr_data_i(mem_insn_i),
    .rd_data_o(rd_insn_w)
  );

  sic_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .fill_en_i  (fill_w),
    .fill_idx_i (pend_idx_q),
    .fill_way_i (pend_way_q),
    .touch_en_i (hit_o),
    .touch_idx_i(idx_w),
    .touch_way_i(hit_way_w),
    .rd_idx_i   (idx_w),
    .rd_lru_o   (lru_w)
  );

  assign lookup_hit_w = |way_hit_w;
  assign hit_way_w    = way_hit_w[1];
  assign conflict_w   = fetch_valid_i && pm_data_i;
  assign victim_w     = pick_victim(way_vld_w[0], way_vld_w[1], lru_w);

  assign hit_o      = conflict_w && lookup_hit_w;
  assign stall_o    = conflict_w && !lookup_hit_w;
  assign hit_insn_o = hit_o ? rd_insn_w : '0;

  assign alloc_w = stall_o && !pend_q;
  assign fill_w  = pend_q && mem_valid_i && !flush_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      pend_tag_q <= '0;
      pend_way_q <= 1'b0;
    end else if (flush_i) begin
      pend_q <= 1'b0;
    end else if (fill_w) begin
      pend_q <= 1'b0;
    end else if (alloc_w) begin
      pend_q     <= 1'b1;
      pend_idx_q <= idx_w;
      pend_tag_q <= tag_w;
      pend_way_q <= victim_w;
    end
  end
endmodule

// File: rtl/sel_icache_chk.sv
module sel_icache_chk (
  input logic clk,
  input logic rst_n,
  input logic flush_i,
  input logic fetch_valid_i,
  input logic pm_data_i,
  input logic hit_o,
  input logic stall_o,
  input logic alloc_w,
  input logic pend_q
);
  AST_STALL_ONLY_ON_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (fetch_valid_i && pm_data_i)); // R2
  AST_HIT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && stall_o)); // R2
  AST_HIT_ONLY_ON_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (fetch_valid_i && pm_data_i)); // R4
  AST_ALLOC_OPENS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_w && !flush_i) |=> pend_q); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !hit_o); // R7
  AST_FLUSH_DROPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !pend_q); // R7
  AST_NO_SECOND_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_w |-> !pend_q); // R8
endmodule

bind sel_icache sel_icache_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush_i      (flush_i),
  .fetch_valid_i(fetch_valid_i),
  .pm_data_i    (pm_data_i),
  .hit_o        (hit_o),
  .stall_o      (stall_o),
  .alloc_w      (alloc_w),
  .pend_q       (pend_q)
);

// File: tb/sel_icache_bench.sv
`timescale 1ns/1ps
module sel_icache_bench;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int NW   = 64;
  localparam int NS   = NW / 2;
  localparam int IW   = $clog2(NS);
  localparam int TW   = AW - IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 1'b0, fetch_valid_i = 1'b0, pm_data_i = 1'b0, mem_valid_i = 1'b0;
  logic [AW-1:0] fetch_addr_i = '0;
  logic [DW-1:0] mem_insn_i = '0;
  logic hit_o, stall_o;
  logic [DW-1:0] hit_insn_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sel_icache #(.ADDR_W(AW), .INSN_W(DW), .WORDS(NW)) u_sel_icache (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .fetch_valid_i(fetch_valid_i),
    .fetch_addr_i(fetch_addr_i), .pm_data_i(pm_data_i), .mem_valid_i(mem_valid_i),
    .mem_insn_i(mem_insn_i), .hit_o(hit_o), .hit_insn_o(hit_insn_o), .stall_o(stall_o)
  );

  // reference model
  bit            m_vld [NS][2];
  bit [TW-1:0]   m_tag [NS][2];
  bit [DW-1:0]   m_dat [NS][2];
  bit            m_lru [NS];
  bit            m_pend;
  int            m_pset;
  bit            m_pway;
  bit [TW-1:0]   m_ptag;

  function automatic bit victim_of(int s);
    if (!m_vld[s][0]) return 1'b0;
    if (!m_vld[s][1]) return 1'b1;
    return m_lru[s];
  endfunction

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit fv, input bit [AW-1:0] a, input bit pmd,
                      input bit mv, input bit [DW-1:0] d, input bit fl, input string rq);
    int  s;
    bit [TW-1:0] t;
    bit  found, hw, ehit, estall, nwv;
    @(negedge clk);
    fetch_valid_i = fv; fetch_addr_i = a; pm_data_i = pmd;
    mem_valid_i = mv; mem_insn_i = d; flush_i = fl;
    #0.5;
    s = int'(a[IW-1:0]);
    t = a[AW-1:IW];
    found = 1'b0; hw = 1'b0;
    for (int w = 0; w < 2; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) begin found = 1'b1; hw = w[0]; end
    ehit   = fv && pmd && found;
    estall = fv && pmd && !found;
    chk(rq, "hit_o", hit_o, ehit);
    chk(rq, "stall_o", stall_o, estall);
    chk(rq, "hit_insn_o", hit_insn_o, ehit ? m_dat[s][hw] : 0);
    // state update for the coming edge
    if (fl) begin
      for (int i = 0; i < NS; i++) begin m_vld[i][0] = 0; m_vld[i][1] = 0; m_lru[i] = 0; end
      m_pend = 0;
    end else begin
      nwv = victim_of(s);
      if (m_pend && mv) begin
        m_vld[m_pset][m_pway] = 1; m_tag[m_pset][m_pway] = m_ptag;
        m_dat[m_pset][m_pway] = d; m_lru[m_pset] = ~m_pway; m_pend = 0;
      end else if (estall && !m_pend) begin
        m_pend = 1; m_pset = s; m_ptag = t; m_pway = nwv;
      end
      if (ehit) m_lru[s] = ~hw;
    end
  endtask

  task automatic idle(input string rq);
    step(0, '0, 0, 0, '0, 0, rq);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin m_vld[i][0] = 0; m_vld[i][1] = 0; m_lru[i] = 0; end
    m_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: idle and empty after reset
    idle("R1");
    step(1, 12'h013, 0, 0, '0, 0, "R1");
    step(1, 12'h013, 1, 0, '0, 0, "R1");          // conflicting miss, pending
    // R3: fill then hit
    step(0, '0, 0, 1, 32'hAAAA0013, 0, "R3");
    step(1, 12'h013, 1, 0, '0, 0, "R3");
    // R4: no-conflict fetch of resident address
    step(1, 12'h013, 0, 0, '0, 0, "R4");
    step(1, 12'h033, 0, 0, '0, 0, "R4");
    // R9: memory word with nothing pending
    step(0, '0, 0, 1, 32'hDEAD0033, 0, "R9");
    step(1, 12'h033, 1, 0, '0, 0, "R9");          // must miss
    step(0, '0, 0, 1, 32'hBBBB0033, 0, "R3");
    // R5: both ways in one set
    step(1, 12'h013, 1, 0, '0, 0, "R5");
    step(1, 12'h033, 1, 0, '0, 0, "R5");
    // R6: touch A, then third tag evicts B
    step(1, 12'h013, 1, 0, '0, 0, "R6");
    step(1, 12'h053, 1, 0, '0, 0, "R6");
    step(0, '0, 0, 1, 32'hCCCC0053, 0, "R6");
    step(1, 12'h033, 1, 0, '0, 0, "R6");
    step(1, 12'h013, 1, 0, '0, 0, "R6");
    step(1, 12'h053, 1, 1, 32'hBBBB0033, 0, "R6"); // hit and fill same set
    step(1, 12'h033, 1, 0, '0, 0, "R6");
    // R8: second miss while pending
    step(1, 12'h101, 1, 0, '0, 0, "R8");
    step(1, 12'h202, 1, 0, '0, 0, "R8");
    step(0, '0, 0, 1, 32'h11110101, 0, "R8");
    step(1, 12'h202, 1, 0, '0, 0, "R8");
    step(1, 12'h101, 1, 0, '0, 0, "R8");
    // R7: flush cancels pending and clears all
    step(0, '0, 0, 1, 32'h22220202, 1, "R7");
    step(0, '0, 0, 1, 32'h33330202, 0, "R7");
    step(1, 12'h202, 1, 0, '0, 0, "R7");
    step(1, 12'h013, 1, 0, '0, 0, "R7");
    step(0, '0, 0, 1, 32'h44440013, 0, "R3");
    // R10: last set index of the capacity
    step(1, 12'hFFF, 1, 0, '0, 0, "R10");
    step(0, '0, 0, 1, 32'h5555FFFF, 0, "R10");
    step(1, 12'hFFF, 1, 0, '0, 0, "R10");
    // random mix: small address pool to force collisions
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      bit [AW-1:0] a;
      a = {5'd0, 2'($urandom), 3'd0, 2'($urandom)};
      step(($urandom % 4) != 0, a, ($urandom % 2) == 0, ($urandom % 10) < 3,
           $urandom, ($urandom % 64) == 0, "R2");
    end
    idle("R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule